// File: doc/BRIEF.md
# Indirect Configuration Access Port with Busy Flag

This block lets a host reach a 128-location, 8-bit configuration store through three direct registers, so that the store never sits on the host bus itself. To write, the host loads the data register and then writes the command register with a direction bit and a 7-bit location. To read, it writes only the command register. In both cases the host then polls the status register until the busy bit drops. Every access takes a fixed number of clock cycles, `ACC_CYCLES`, which models a cycle of about half a microsecond. When a read finishes, the value fetched is left in the data register.

The location space is split into three regions of 32 or 31 entries, each indexed by timeslot: one for per-timeslot configuration octets, one for per-timeslot 8-bit trunk codes, and one for per-timeslot four-bit signaling values. Locations outside these regions hold nothing.

A write to the command or data register while an access is in progress is dropped, and a sticky error bit records it. The host clears that bit explicitly.

Top module: `ind_reg_port`

## Requirements
- R1: A write to the command register (select 0) while not busy starts an access. Bit 7 is the direction (1 = read, 0 = write) and bits 6:0 are the location. `busy` is high from the next cycle, and the command register reads back the written byte.
- R2: `busy`, and bit 7 of the status register, stay high for exactly `ACC_CYCLES` clock cycles after the command write, then clear.
- R3: A write access stores the data register (select 1) into the addressed location on the cycle the access completes.
- R4: A read access loads the data register with the stored value of the addressed location when the access completes. Until then the data register keeps its previous value.
- R5: A write to the command or data register while `busy` is high has no effect on either register or on the access in progress, and it sets the error bit (status bit 0).
- R6: The error bit is sticky. Only a write to the status register (select 2) with bit 0 set clears it.
- R7: Locations 20h to 3Fh (configuration) and 40h to 5Fh (trunk codes) hold all 8 bits.
- R8: Locations 61h to 7Fh (signaling) hold only bits 3:0. Bits 7:4 always read back as 0.
- R9: Locations 00h to 1Fh and 60h store nothing, and a read access to them returns 0.
- R10: After reset, all three direct registers read 0, `busy` is low, and every location reads back 0.
- R11: The status register reads busy in bit 7, error in bit 0, and zero in bits 6:1. Select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Host write strobe for the selected direct register |
| cpu_sel | input | 2 | Direct register select: 0 command, 1 data, 2 status |
| cpu_wdata | input | 8 | Host write data |
| cpu_rdata | output | 8 | Contents of the selected direct register (combinational) |
| busy | output | 1 | High while an access is in progress |

## Verification
The bench goes after the edge where an access completes. A busy window that is one cycle too long or too short shows up as a `busy` mismatch on the first or last cycle. A read that lands one cycle late leaves stale data visible in the data register. Host writes made during the busy window test the R5 guard: a design that let them through would retarget the access or corrupt the write data, and the damage would appear on a later read-back. Accesses at each region's first and last location, at 60h and at 00h–1Fh, and with all-ones data into the signaling region, expose a decoder that is off by one or that does not mask the upper nibble.

// File: rtl/irp_pkg.sv
package irp_pkg;

    localparam int unsigned LOC_W = 7;
    localparam int unsigned OCT_W = 8;

    localparam logic [1:0] SEL_CMD  = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_STAT = 2'd2;

    typedef enum logic [1:0] {
        RGN_NONE  = 2'd0,
        RGN_CFG   = 2'd1,
        RGN_TRUNK = 2'd2,
        RGN_SIG   = 2'd3
    } region_e;

    localparam logic [LOC_W-1:0] CFG_LO   = 7'h20;
    localparam logic [LOC_W-1:0] CFG_HI   = 7'h3F;
    localparam logic [LOC_W-1:0] TRUNK_LO = 7'h40;
    localparam logic [LOC_W-1:0] TRUNK_HI = 7'h5F;
    localparam logic [LOC_W-1:0] SIG_LO   = 7'h61;
    localparam logic [LOC_W-1:0] SIG_HI   = 7'h7F;

    localparam logic [OCT_W-1:0] SIG_KEEP = 8'h0F;

endpackage

// File: rtl/irp_region_dec.sv
module irp_region_dec
    import irp_pkg::*;
(
    input  logic [LOC_W-1:0] loc_i,
    output region_e          region_o,
    output logic [OCT_W-1:0] keep_o
);

    always_comb begin
        region_o = RGN_NONE;
        if (loc_i >= CFG_LO && loc_i <= CFG_HI) begin
            region_o = RGN_CFG;
        end else if (loc_i >= TRUNK_LO && loc_i <= TRUNK_HI) begin
            region_o = RGN_TRUNK;
        end else if (loc_i >= SIG_LO && loc_i <= SIG_HI) begin
            region_o = RGN_SIG;
        end
    end

    always_comb begin
        unique case (region_o)
            RGN_CFG:   keep_o = '1;
            RGN_TRUNK: keep_o = '1;
            RGN_SIG:   keep_o = SIG_KEEP;
            default:   keep_o = '0;
        endcase
    end

endmodule

// File: rtl/irp_store.sv
module irp_store
    import irp_pkg::*;
#(
    parameter int unsigned AW = LOC_W,
    parameter int unsigned DW = OCT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] keep_i,
    output logic [DW-1:0] rdata_o
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_loc
        logic [DW-1:0] loc_d;
        always_comb begin
            loc_d = mem_q[gi];
            if (we_i && addr_i == AW'(gi)) begin
                loc_d = wdata_i & keep_i;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[gi] <= '0;
            end else begin
                mem_q[gi] <= loc_d;
            end
        end
    end

    assign rdata_o = mem_q[addr_i] & keep_i;

    // A location whose keep mask is zero must never gain a set bit.
    p_masked_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && keep_i == '0) |=> (mem_q[$past(addr_i)] == '0))
        else $error("write into unmapped location changed it");

endmodule

// File: rtl/irp_seq.sv
module irp_seq #(
    parameter int unsigned ACC_CYCLES = 62
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam int unsigned CNT_W = (ACC_CYCLES < 2) ? 1 : $clog2(ACC_CYCLES);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACC_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d  = seq_q;
        done_o = seq_q.busy && (seq_q.cnt == '0);
        if (seq_q.busy) begin
            if (done_o) begin
                seq_d.busy = 1'b0;
            end else begin
                seq_d.cnt = seq_q.cnt - 1'b1;
            end
        end else if (start_i) begin
            seq_d.busy = 1'b1;
            seq_d.cnt  = CNT_LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o = seq_q.busy;

    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o)
        else $error("accepted start did not raise busy");

    p_busy_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o)
        else $error("busy dropped before the access finished");

    p_busy_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o)
        else $error("busy still high after completion");

endmodule

// File: rtl/ind_reg_port.sv
module ind_reg_port
    import irp_pkg::*;
#(
    parameter int unsigned ACC_CYCLES = 62
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic [1:0]       cpu_sel,
    input  logic [OCT_W-1:0] cpu_wdata,
    output logic [OCT_W-1:0] cpu_rdata,
    output logic             busy
);

    localparam int unsigned STAT_PAD = OCT_W - 2;

    typedef struct packed {
        logic             dir;
        logic [LOC_W-1:0] loc;
        logic [OCT_W-1:0] data;
        logic             err;
    } regs_t;

    regs_t regs_d, regs_q;

    logic             start;
    logic             done;
    logic             busy_int;
    region_e          region;
    logic [OCT_W-1:0] keep;
    logic [OCT_W-1:0] store_rdata;
    logic             store_we;

    irp_seq #(.ACC_CYCLES(ACC_CYCLES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy_int),
        .done_o  (done)
    );

    irp_region_dec u_dec (
        .loc_i    (regs_q.loc),
        .region_o (region),
        .keep_o   (keep)
    );

    irp_store #(.AW(LOC_W), .DW(OCT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (store_we),
        .addr_i  (regs_q.loc),
        .wdata_i (regs_q.data),
        .keep_i  (keep),
        .rdata_o (store_rdata)
    );

    assign start    = cpu_wr && (cpu_sel == SEL_CMD) && !busy_int;
    assign store_we = done && !regs_q.dir;

    always_comb begin
        regs_d = regs_q;
        if (done && regs_q.dir) begin
            regs_d.data = store_rdata;
        end
        if (cpu_wr) begin
            unique case (cpu_sel)
                SEL_CMD: begin
                    if (busy_int) begin
                        regs_d.err = 1'b1;
                    end else begin
                        regs_d.dir = cpu_wdata[OCT_W-1];
                        regs_d.loc = cpu_wdata[LOC_W-1:0];
                    end
                end
                SEL_DATA: begin
                    if (busy_int) begin
                        regs_d.err = 1'b1;
                    end else begin
                        regs_d.data = cpu_wdata;
                    end
                end
                SEL_STAT: begin
                    if (cpu_wdata[0]) begin
                        regs_d.err = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        unique case (cpu_sel)
            SEL_CMD:  cpu_rdata = {regs_q.dir, regs_q.loc};
            SEL_DATA: cpu_rdata = regs_q.data;
            SEL_STAT: cpu_rdata = {busy_int, {STAT_PAD{1'b0}}, regs_q.err};
            default:  cpu_rdata = '0;
        endcase
    end

    assign busy = busy_int;

    p_busy_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_wr && (cpu_sel == SEL_CMD || cpu_sel == SEL_DATA)) |=> regs_q.err)
        else $error("rejected write did not flag error");

    p_cmd_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({regs_q.dir, regs_q.loc}))
        else $error("command changed during an access");

    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(regs_q.data))
        else $error("data register moved before completion");

    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.err && !(cpu_wr && cpu_sel == SEL_STAT && cpu_wdata[0])) |=> regs_q.err)
        else $error("error bit cleared without a clear write");

endmodule

// File: tb/ind_reg_port_bench.sv
module ind_reg_port_bench;

    localparam int ACC = 62;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [1:0] cpu_sel = 2'd0;
    logic [7:0] cpu_wdata = 8'd0;
    logic [7:0] cpu_rdata;
    logic       busy;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // behavioural reference state
    int  m_mem [128];
    bit  m_busy;
    int  m_cnt;
    bit  m_dir;
    int  m_loc;
    int  m_data;
    bit  m_err;
    string tag = "R10";

    always #4 clk = ~clk;

    ind_reg_port #(.ACC_CYCLES(ACC)) u_ind_reg_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_sel   (cpu_sel),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .busy      (busy)
    );

    function automatic int keep_of(int loc);
        if (loc >= 'h20 && loc <= 'h5F) return 'hFF;
        if (loc >= 'h61 && loc <= 'h7F) return 'h0F;
        return 0;
    endfunction

    function automatic int model_rd(int sel);
        case (sel)
            0: return (int'(m_dir) << 7) | m_loc;
            1: return m_data;
            2: return (int'(m_busy) << 7) | int'(m_err);
            default: return 0;
        endcase
    endfunction

    task automatic model_edge(bit wr, int sel, int wd);
        bit was_busy = m_busy;
        if (m_busy) begin
            if (m_cnt == 1) begin
                m_busy = 1'b0;
                if (m_dir) m_data = m_mem[m_loc] & keep_of(m_loc);
                else       m_mem[m_loc] = m_data & keep_of(m_loc);
            end else begin
                m_cnt--;
            end
        end
        if (wr) begin
            if (sel == 0) begin
                if (was_busy) m_err = 1'b1;
                else begin
                    m_dir = wd[7]; m_loc = wd & 'h7F; m_busy = 1'b1; m_cnt = ACC;
                end
            end else if (sel == 1) begin
                if (was_busy) m_err = 1'b1;
                else m_data = wd;
            end else if (sel == 2) begin
                if (wd[0]) m_err = 1'b0;
            end
        end
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, compare, advance model, wait for edge
    task automatic step(bit wr, int sel, int wd);
        @(negedge clk);
        cpu_wr = wr; cpu_sel = 2'(sel); cpu_wdata = 8'(wd);
        #1;
        check(tag, int'(cpu_rdata), model_rd(sel));
        check("R2", int'(busy), int'(m_busy));
        model_edge(wr, sel, wd);
        @(posedge clk);
    endtask

    task automatic wait_idle();
        step(0, 2, 0);
        while (m_busy) step(0, 2, 0);
    endtask

    task automatic write_loc(int loc, int val);
        step(1, 1, val);
        step(1, 0, loc & 'h7F);
        wait_idle();
    endtask

    task automatic read_loc(int loc);
        step(1, 0, 'h80 | loc);
        wait_idle();
        step(0, 1, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) m_mem[i] = 0;
        m_busy = 0; m_cnt = 0; m_dir = 0; m_loc = 0; m_data = 0; m_err = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        tag = "R10"; // reset state of every register
        step(0, 0, 0); step(0, 1, 0); step(0, 2, 0);
        tag = "R11"; step(0, 3, 0);
        tag = "R10"; read_loc('h25);

        tag = "R1"; step(1, 1, 'h5A); step(1, 0, 'h25); step(0, 0, 0);
        tag = "R3"; wait_idle();
        tag = "R4"; step(1, 1, 'h11); read_loc('h25);

        tag = "R7";
        write_loc('h20, 'hA5); write_loc('h3F, 'h3C);
        write_loc('h40, 'hC3); write_loc('h5F, 'hFF);
        read_loc('h20); read_loc('h3F); read_loc('h40); read_loc('h5F);

        tag = "R8";
        write_loc('h61, 'hFF); write_loc('h7F, 'hB6); write_loc('h70, 'h9E);
        read_loc('h61); read_loc('h7F); read_loc('h70);

        tag = "R9";
        write_loc('h60, 'hFF); write_loc('h10, 'h77); write_loc('h00, 'h81);
        read_loc('h60); read_loc('h10); read_loc('h00);

        tag = "R5"; // host writes during an access are dropped
        step(1, 1, 'h6D); step(1, 0, 'h33);
        step(1, 0, 'h80 | 'h44); step(1, 1, 'h00); step(0, 0, 0); step(0, 1, 0);
        step(0, 2, 0);
        wait_idle();
        read_loc('h33);
        read_loc('h44);

        tag = "R6"; // sticky until cleared with bit 0
        step(1, 2, 'hFE); step(0, 2, 0); step(1, 2, 'h01); step(0, 2, 0);

        tag = "R5"; // reject on the last busy cycle too
        step(1, 1, 'h42); step(1, 0, 'h22);
        for (int k = 0; k < ACC - 1; k++) step(0, 2, 0);
        step(1, 0, 'h80 | 'h22);
        step(0, 2, 0); step(0, 0, 0);
        tag = "R6"; step(1, 2, 'h01); step(0, 2, 0);
        tag = "R4"; read_loc('h22);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule